// File: doc/BRIEF.md
# Clone-Bit Micro-Op Fission Dispatcher

This block takes one decoded micro-op stream from a single decoder and fans it out to the rename ports of several hardware thread contexts (two or four, set by a parameter). A micro-op with its clone bit set is copied into every enabled context. One micro-op fetched and decoded once can therefore fill several back-end pipelines running iterations of the same loop. A micro-op without the clone bit goes only to the context named in its context field.

Three special kinds exist for loop set-up and tear-down. A vector assign hands each context its own element of a value list, for example a distinct starting loop index. A broadcast assign writes the same live-in value into the same register of every context. A drain barrier is never forwarded. After it is taken, no further input is accepted until every enabled context has an empty dispatch port and reports an empty reorder buffer. A per-context enable mask sets which contexts take part. Each context port holds one micro-op in a register and uses a valid/ready handshake.

Top module: `fission_dispatch`

## Requirements
- R1: While reset is asserted and right after it, every `out_valid` bit is low and `in_ready` is high.
- R2: A micro-op of kind 0 (plain) with `in_clone` set appears one cycle after acceptance on every enabled context port. Each copy carries the same kind, destination register and data.
- R3: A plain micro-op with `in_clone` clear appears only on the port selected by `in_ctx`. If that context is disabled, the micro-op is accepted and dropped.
- R4: A micro-op of kind 1 (vector assign) gives context k the data element `in_vec[k*DATA_W +: DATA_W]`. Elements for disabled contexts are dropped, and the clone bit has no effect.
- R5: A micro-op of kind 2 (broadcast assign) puts `in_data` and `in_dst` on every enabled context port.
- R6: `in_ready` is high only when every target port of the offered micro-op can take it in that cycle. An accepted micro-op reaches all of its targets, and a refused one reaches none of them.
- R7: Each port holds at most one micro-op. While it is valid and not ready, its contents do not change. It can take a new micro-op in the same cycle its current one leaves. Micro-ops leave each port in acceptance order.
- R8: A micro-op of kind 3 (drain barrier) is accepted without producing any output. From the next cycle, `in_ready` stays low until a cycle in which every enabled context has `out_valid` low and `rob_empty` high. `in_ready` may rise again in the following cycle. `rob_empty` of disabled contexts is ignored.
- R9: Port k drives `out_ctx` equal to k and `out_kind` equal to the accepted kind. It never presents kind 3.
- R10: Reset clears a pending barrier, so `in_ready` is high after reset even while `rob_empty` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctx_en | input | N_CTX | Per-context enable mask |
| in_valid | input | 1 | Decoded micro-op offered |
| in_ready | output | 1 | Micro-op taken this cycle when valid |
| in_kind | input | 2 | 0 plain, 1 vector assign, 2 broadcast assign, 3 drain barrier |
| in_clone | input | 1 | Clone bit for plain micro-ops |
| in_ctx | input | CTX_W | Owning context of an unmarked micro-op |
| in_dst | input | REG_W | Destination register |
| in_data | input | DATA_W | Operand or live-in value |
| in_vec | input | N_CTX*DATA_W | Per-context element list for vector assign |
| rob_empty | input | N_CTX | Reorder buffer of each context is empty |
| out_valid | output | N_CTX | Port k holds a micro-op |
| out_ready | input | N_CTX | Rename stage k takes the micro-op |
| out_kind | output | N_CTX*2 | Kind per port |
| out_dst | output | N_CTX*REG_W | Destination register per port |
| out_data | output | N_CTX*DATA_W | Data per port |
| out_ctx | output | N_CTX*CTX_W | Context tag per port |

## Verification
Cloned plain micro-ops under random back-pressure test fan-out. They show whether a single stalled port holds back the whole input rather than letting partial copies through. Unmarked micro-ops whose context rotates each cycle test that routing goes by `in_ctx` and not by clone. Vector assigns under changing enable masks separate per-element selection from broadcast and catch dropped or misplaced elements. A mixed stream with barriers and random `rob_empty` exercises the drain condition. It ends with a reset taken while a barrier is pending, which checks that the barrier state clears.

// File: rtl/fission_pkg.sv
package fission_pkg;
  typedef enum logic [1:0] {
    OPK_PLAIN = 2'd0,
    OPK_VEC   = 2'd1,
    OPK_BCAST = 2'd2,
    OPK_WAIT  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/fission_target.sv
module fission_target
  import fission_pkg::*;
#(
  parameter int N_CTX = 4,
  parameter int CTX_W = 2
) (
  input  op_kind_e         kind,
  input  logic             clone,
  input  logic [CTX_W-1:0] ctx,
  input  logic [N_CTX-1:0] ctx_en,
  output logic [N_CTX-1:0] tgt
);
  logic [N_CTX-1:0] own;

  generate
    for (genvar k = 0; k < N_CTX; k++) begin : g_own
      assign own[k] = (ctx == CTX_W'(k));
    end
  endgenerate

  always_comb begin
    unique case (kind)
      OPK_PLAIN: tgt = clone ? ctx_en : (own & ctx_en);
      OPK_VEC,
      OPK_BCAST: tgt = ctx_en;
      default:   tgt = '0;
    endcase
  end
endmodule

// File: rtl/fission_lane.sv
module fission_lane #(
  parameter int PW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] d,
  input  logic          out_ready,
  output logic          free,
  output logic          out_valid,
  output logic [PW-1:0] q
);
  logic          vld_q, vld_d;
  logic [PW-1:0] pay_q;

  assign free      = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign q         = pay_q;

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) pay_q <= d;
  end
endmodule

// File: rtl/fission_barrier.sv
module fission_barrier #(
  parameter int N_CTX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_fire,
  input  logic [N_CTX-1:0] ctx_en,
  input  logic [N_CTX-1:0] port_busy,
  input  logic [N_CTX-1:0] rob_empty,
  output logic             pending
);
  logic pend_q, pend_d, drained;

  assign drained = &(~ctx_en | (~port_busy & rob_empty));
  assign pending = pend_q;

  always_comb begin
    pend_d = pend_q;
    if (pend_q && drained) pend_d = 1'b0;
    else if (wait_fire)    pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/fission_dispatch.sv
module fission_dispatch
  import fission_pkg::*;
#(
  parameter int N_CTX  = 4,
  parameter int DATA_W = 16,
  parameter int REG_W  = 5,
  localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1,
  localparam int PW    = 2 + REG_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CTX-1:0]        ctx_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_kind,
  input  logic                    in_clone,
  input  logic [CTX_W-1:0]        in_ctx,
  input  logic [REG_W-1:0]        in_dst,
  input  logic [DATA_W-1:0]       in_data,
  input  logic [N_CTX*DATA_W-1:0] in_vec,
  input  logic [N_CTX-1:0]        rob_empty,
  output logic [N_CTX-1:0]        out_valid,
  input  logic [N_CTX-1:0]        out_ready,
  output logic [N_CTX*2-1:0]      out_kind,
  output logic [N_CTX*REG_W-1:0]  out_dst,
  output logic [N_CTX*DATA_W-1:0] out_data,
  output logic [N_CTX*CTX_W-1:0]  out_ctx
);
  op_kind_e         kind;
  logic [N_CTX-1:0] tgt, lane_free, lane_load;
  logic             is_wait, room, pending, fire;

  assign kind    = op_kind_e'(in_kind);
  assign is_wait = (kind == OPK_WAIT);

  fission_target #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_tgt (
    .kind(kind), .clone(in_clone), .ctx(in_ctx), .ctx_en(ctx_en), .tgt(tgt)
  );

  assign room      = &(lane_free | ~tgt);
  assign in_ready  = !pending && (is_wait || room);
  assign fire      = in_valid && in_ready;
  assign lane_load = {N_CTX{fire && !is_wait}} & tgt;

  fission_barrier #(.N_CTX(N_CTX)) u_bar (
    .clk(clk), .rst_n(rst_n), .wait_fire(fire && is_wait), .ctx_en(ctx_en),
    .port_busy(out_valid), .rob_empty(rob_empty), .pending(pending)
  );

  generate
    for (genvar k = 0; k < N_CTX; k++) begin : g_lane
      logic [DATA_W-1:0] val;
      logic [PW-1:0]     d, q;
      assign val = (kind == OPK_VEC) ? in_vec[k*DATA_W +: DATA_W] : in_data;
      assign d   = {in_kind, in_dst, val};

      fission_lane #(.PW(PW)) u_lane (
        .clk(clk), .rst_n(rst_n), .load(lane_load[k]), .d(d),
        .out_ready(out_ready[k]), .free(lane_free[k]),
        .out_valid(out_valid[k]), .q(q)
      );

      assign out_kind[k*2 +: 2]          = q[PW-1 -: 2];
      assign out_dst[k*REG_W +: REG_W]   = q[DATA_W +: REG_W];
      assign out_data[k*DATA_W +: DATA_W] = q[DATA_W-1:0];
      assign out_ctx[k*CTX_W +: CTX_W]   = CTX_W'(k);
    end
  endgenerate
endmodule

// File: rtl/fission_dispatch_chk.sv
module fission_dispatch_chk
  import fission_pkg::*;
#(
  parameter int N_CTX  = 4,
  parameter int DATA_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CTX-1:0]        ctx_en,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [1:0]              in_kind,
  input logic                    in_clone,
  input logic [N_CTX*DATA_W-1:0] in_vec,
  input logic [N_CTX-1:0]        out_valid,
  input logic [N_CTX-1:0]        out_ready,
  input logic [N_CTX*2-1:0]      out_kind,
  input logic [N_CTX*DATA_W-1:0] out_data
);
  assert_wait_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == OPK_WAIT) |=> !in_ready);

  assert_clone_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == OPK_PLAIN && in_clone)
      |=> ((out_valid & $past(ctx_en)) == $past(ctx_en)));

  generate
    for (genvar k = 0; k < N_CTX; k++) begin : g_chk
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[k] && !out_ready[k]) |=>
          (out_valid[k] && $stable(out_data[k*DATA_W +: DATA_W])
           && $stable(out_kind[k*2 +: 2])));

      assert_vec_elem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == OPK_VEC && ctx_en[k]) |=>
          (out_valid[k] && out_data[k*DATA_W +: DATA_W] == $past(in_vec[k*DATA_W +: DATA_W])));

      assert_no_wait_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[k] |-> (out_kind[k*2 +: 2] != OPK_WAIT));
    end
  endgenerate
endmodule

bind fission_dispatch fission_dispatch_chk #(.N_CTX(N_CTX), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctx_en(ctx_en), .in_valid(in_valid),
  .in_ready(in_ready), .in_kind(in_kind), .in_clone(in_clone), .in_vec(in_vec),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_data(out_data)
);

// File: tb/tb_fission_dispatch.sv
module tb_fission_dispatch;
  localparam int N = 4;
  localparam int DW = 16;
  localparam int RW = 5;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] ctx_en, rob_empty, out_valid, out_ready;
  logic in_valid, in_ready, in_clone;
  logic [1:0] in_kind;
  logic [CW-1:0] in_ctx;
  logic [RW-1:0] in_dst;
  logic [DW-1:0] in_data;
  logic [N*DW-1:0] in_vec, out_data;
  logic [N*2-1:0] out_kind;
  logic [N*RW-1:0] out_dst;
  logic [N*CW-1:0] out_ctx;

  always #5 clk = ~clk;

  fission_dispatch #(.N_CTX(N), .DATA_W(DW), .REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .ctx_en(ctx_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_kind(in_kind), .in_clone(in_clone),
    .in_ctx(in_ctx), .in_dst(in_dst), .in_data(in_data), .in_vec(in_vec),
    .rob_empty(rob_empty), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_dst(out_dst), .out_data(out_data),
    .out_ctx(out_ctx)
  );

  typedef struct {
    logic [1:0]    k;
    logic [RW-1:0] d;
    logic [DW-1:0] v;
    string         r;
  } item_t;

  item_t mq[N][$];
  bit    pend;
  bit    acc;
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] targets();
    case (in_kind)
      2'd0: return in_clone ? ctx_en : (ctx_en[in_ctx] ? (N'(1) << in_ctx) : '0);
      2'd1, 2'd2: return ctx_en;
      default: return '0;
    endcase
  endfunction

  // Compares the ports against the model and then advances the model
  // by the handshakes that take effect at the coming clock edge.
  task automatic eval();
    logic [N-1:0] t;
    bit exp_rdy, drained;
    t = targets();
    for (int k = 0; k < N; k++) begin
      string tag;
      tag = (mq[k].size() != 0) ? mq[k][0].r : "R3";
      chk(out_valid[k] == (mq[k].size() != 0), {tag, "/R6"}, "out_valid",
          out_valid[k], mq[k].size() != 0);
      chk(out_ctx[k*CW +: CW] == CW'(k), "R9", "out_ctx", out_ctx[k*CW +: CW], k);
      if (out_valid[k] && mq[k].size() != 0) begin
        chk(out_kind[k*2 +: 2] == mq[k][0].k, {mq[k][0].r, "/R9"}, "out_kind",
            out_kind[k*2 +: 2], mq[k][0].k);
        chk(out_dst[k*RW +: RW] == mq[k][0].d, {mq[k][0].r, "/R7"}, "out_dst",
            out_dst[k*RW +: RW], mq[k][0].d);
        chk(out_data[k*DW +: DW] == mq[k][0].v, {mq[k][0].r, "/R7"}, "out_data",
            out_data[k*DW +: DW], mq[k][0].v);
      end
    end
    exp_rdy = 1'b1;
    if (pend) exp_rdy = 1'b0;
    else if (in_kind != 2'd3)
      for (int k = 0; k < N; k++)
        if (t[k] && mq[k].size() != 0 && !out_ready[k]) exp_rdy = 1'b0;
    chk(in_ready == exp_rdy, pend ? "R8" : "R6", "in_ready", in_ready, exp_rdy);

    drained = 1'b1;
    for (int k = 0; k < N; k++)
      if (ctx_en[k] && (mq[k].size() != 0 || !rob_empty[k])) drained = 1'b0;

    acc = in_valid && in_ready;
    for (int k = 0; k < N; k++)
      if (out_valid[k] && out_ready[k] && mq[k].size() != 0) void'(mq[k].pop_front());
    if (acc && in_kind != 2'd3) begin
      for (int k = 0; k < N; k++) begin
        if (t[k]) begin
          item_t it;
          it.k = in_kind;
          it.d = in_dst;
          it.v = (in_kind == 2'd1) ? in_vec[k*DW +: DW] : in_data;
          it.r = (in_kind == 2'd1) ? "R4" : (in_kind == 2'd2) ? "R5" :
                 in_clone ? "R2" : "R3";
          mq[k].push_back(it);
        end
      end
    end
    if (pend && drained) pend = 1'b0;
    else if (acc && in_kind == 2'd3) pend = 1'b1;
  endtask

  task automatic new_op(input int phase, input int n);
    in_valid = ($urandom_range(0, 7) != 0);
    in_dst   = RW'($urandom);
    in_data  = DW'($urandom);
    for (int k = 0; k < N; k++) in_vec[k*DW +: DW] = DW'($urandom);
    in_clone = 1'b0;
    in_ctx   = CW'($urandom);
    case (phase)
      0: begin in_kind = 2'd0; in_clone = 1'b1; ctx_en = '1; end
      1: begin in_kind = 2'd0; in_ctx = CW'(n); end           // R3 rotation
      2: begin in_kind = 2'd1; in_clone = 1'($urandom); ctx_en = N'($urandom); end
      3: begin in_kind = 2'd2; ctx_en = N'($urandom); end
      default: begin
        in_kind  = 2'($urandom);
        in_clone = 1'($urandom);
        ctx_en   = N'($urandom);
      end
    endcase
  endtask

  task automatic run_phase(input int phase, input int cycles);
    for (int n = 0; n < cycles; n++) begin
      @(posedge clk); #1;
      if (!in_valid || acc) new_op(phase, n);
      for (int k = 0; k < N; k++) begin
        out_ready[k] = (phase == 4 && k == 2) ? ($urandom_range(0, 9) == 0)
                                              : ($urandom_range(0, 3) != 0);
        rob_empty[k] = 1'($urandom);
      end
      @(negedge clk);
      eval();
    end
  endtask

  task automatic reset_check();
    @(posedge clk); #1;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_kind = 2'd0;
    rob_empty = '0;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    for (int k = 0; k < N; k++) mq[k].delete();
    pend = 1'b0;
    acc = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", "in_ready after reset, rob busy", in_ready, 1);
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    eval();
  endtask

  initial begin
    rst_n = 1'b0;
    ctx_en = '1; rob_empty = '0; out_ready = '0;
    in_valid = 1'b0; in_kind = 2'd0; in_clone = 1'b0; in_ctx = '0;
    in_dst = '0; in_data = '0; in_vec = '0;
    pend = 1'b0; acc = 1'b0;
    repeat (2) @(posedge clk);
    reset_check();
    for (int p = 0; p < 5; p++) run_phase(p, 600);
    // Leave a barrier pending, then reset on top of it (R10).
    @(posedge clk); #1;
    ctx_en = '1; in_valid = 1'b1; in_kind = 2'd3; rob_empty = '0; out_ready = '1;
    @(negedge clk);
    eval();
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(pend && !in_ready, "R8", "barrier holds with rob busy", in_ready, 0);
    eval();
    reset_check();
    run_phase(5, 600);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule